// File: doc/BRIEF.md
# I2C Register-Transfer Sequencer

This block drives a status-coded I2C byte engine through complete register-style transfers. One command names a 7-bit chip address, an offset of zero to four bytes, a data length and a transfer kind: write, combined read, or presence probe. The sequencer then issues the engine steps one at a time. These are START, a byte send, a byte receive with ACK or NAK, and STOP. It takes write bytes from a pop-style stream and hands each received byte out with a one-cycle valid.

After each step the sequencer waits for the engine's interrupt flag, bounded by a tick-based timeout. One cycle after the flag it compares the engine status with the code that step must produce. On a mismatch or a timeout it abandons the rest of the transfer. It always closes with STOP and reports one packed 32-bit diagnostic word alongside a one-cycle done pulse. The word is zero on success.

The controller is a single FSM with these states:
- IDLE: accepts a command.
- ISSUE: pulses one engine step.
- WAIT: waits for the flag or the timeout.
- SAMPLE: compares the status one cycle after the flag.
- STOP_ISSUE: pulses STOP.
- STOP_WAIT: waits for the idle status or the timeout.
- FINISH: pulses done.

Its transitions are:
- IDLE→ISSUE on `cmd_valid`.
- ISSUE→WAIT.
- WAIT→SAMPLE on the flag.
- WAIT→STOP_ISSUE on timeout.
- SAMPLE→ISSUE when the status matches and steps remain.
- SAMPLE→STOP_ISSUE on a mismatch or after the last step.
- STOP_ISSUE→STOP_WAIT.
- STOP_WAIT→FINISH on idle status or on timeout.
- FINISH→IDLE.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset `busy`, `done`, `eng_op_valid`, `rd_valid` and `wr_pop` are low and `err_word` is zero.
- R2: A command is accepted when `cmd_valid` is high in IDLE. `busy` is high from the next cycle until the transfer ends. `done` then pulses for exactly one cycle with `busy` low, and `err_word` is zero when no error occurred. `cmd_kind` encodes 0 as write, 1 as read, and 2 or 3 as probe.
- R3: A write issues START (expects 0x08), then the address byte `{chip,0}` (expects 0x18), then the offset bytes, then `cmd_len` data bytes from `wr_data` (each popped with `wr_pop` and expecting 0x28), then STOP. Offset bytes go from index `cmd_off_cnt-1` down to index 0, where byte i is `cmd_offset[8i+7:8i]`.
- R4: A read with a nonzero offset count first runs START, `{chip,0}` and the offset bytes as in R3. It then issues a second START with no STOP in between, which expects 0x10, followed by `{chip,1}`, which expects 0x40.
- R5: A read with a zero offset count issues START (expects 0x08) directly followed by `{chip,1}` (expects 0x40).
- R6: Every received byte except the last uses receive-with-ACK (expects 0x50, control 0x44). The last uses receive-with-NAK (expects 0x58, control 0x40). Each accepted byte appears on `rd_data` with a one-cycle `rd_valid`. A read with length 0 goes from the address step straight to STOP.
- R7: A probe issues START, `{chip,1}` and one receive-with-NAK, then STOP, and delivers the dummy byte.
- R8: The status is compared in the cycle after the flag is first seen, so a status that updates one cycle after the flag is still judged correctly.
- R9: A status that differs from the expected code aborts the transfer with error class 1. The error word holds the class in bits 31:24, the step's control byte with the flag bit 0x08 set in 23:16, the observed status in 15:8, and the expected code in 7:0. Control bytes are built from enable 0x40, start 0x20, stop 0x10 and ack 0x04.
- R10: A step whose flag does not arrive within `TIMEOUT_TICKS` ticks of `TICK_CYCLES` clocks aborts with class 2. The word then holds the step's control byte without the flag bit, the current status, and the expected code. A response slower than usual but inside the window is not an error.
- R11: STOP (opcode 5, control 0x50) ends every transfer, including aborted ones. The transfer then waits for status 0xF8. A STOP timeout yields `{2, 0x50, status, 0xF8}` only when no earlier error occurred, so the first error is the one reported.
- R12: Engine opcodes are 1 START, 2 send, 3 receive-ACK, 4 receive-NAK and 5 STOP. Each is a one-cycle `eng_op_valid` pulse, and no two steps are issued in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken in IDLE |
| cmd_kind | input | 2 | 0 write, 1 read, 2/3 probe |
| cmd_chip | input | 7 | 7-bit chip address |
| cmd_offset | input | 32 | Offset, little-endian byte order |
| cmd_off_cnt | input | 3 | Number of offset bytes, 0 to 4 |
| cmd_len | input | 8 | Number of data bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_word | output | 32 | Packed diagnostic word, zero on success |
| wr_data | input | 8 | Next write data byte |
| wr_pop | output | 1 | Write byte consumed this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Received byte valid |
| eng_op_valid | output | 1 | Engine step request pulse |
| eng_op | output | 3 | Engine step opcode |
| eng_tx | output | 8 | Byte to send |
| eng_flag | input | 1 | Engine interrupt flag |
| eng_status | input | 8 | Engine status code |
| eng_rx | input | 8 | Byte received by the engine |

## Verification
The bench drives several transfer shapes against an engine model that derives its status codes from the bus protocol alone:
- A two-byte-offset write tells byte ordering apart from index ordering.
- A four-byte-offset write with no data checks the full offset range.
- Combined reads with and without offsets separate the repeated-START path from the direct-read path, and a one-byte read checks the NAK-only case.
- A probe checks the dummy NAK.

Injected faults at the address step, at a mid-read step and at STOP distinguish a status error from a step timeout and from a STOP timeout. The two faults together check that the first error wins. A slow engine separates a genuine timeout from a merely late response, and a status that lags the flag by one cycle tells the delayed sampling apart from sampling at the flag.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_PROBE = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_START    = 3'd1,
        OP_SEND     = 3'd2,
        OP_RECV_ACK = 3'd3,
        OP_RECV_NAK = 3'd4,
        OP_STOP     = 3'd5
    } eng_op_e;

    typedef enum logic [2:0] {
        STEP_START,
        STEP_ADDR_W,
        STEP_OFFSET,
        STEP_RESTART,
        STEP_ADDR_R,
        STEP_WDATA,
        STEP_RDATA,
        STEP_END
    } step_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_SAMPLE,
        ST_STOP_ISSUE,
        ST_STOP_WAIT,
        ST_FINISH
    } seq_state_e;

    localparam logic [7:0] CODE_START      = 8'h08;
    localparam logic [7:0] CODE_RESTART    = 8'h10;
    localparam logic [7:0] CODE_ADDR_W_ACK = 8'h18;
    localparam logic [7:0] CODE_WDATA_ACK  = 8'h28;
    localparam logic [7:0] CODE_ADDR_R_ACK = 8'h40;
    localparam logic [7:0] CODE_RDATA_ACK  = 8'h50;
    localparam logic [7:0] CODE_RDATA_NAK  = 8'h58;
    localparam logic [7:0] CODE_IDLE       = 8'hF8;

    localparam logic [7:0] CTL_ACK   = 8'h04;
    localparam logic [7:0] CTL_FLAG  = 8'h08;
    localparam logic [7:0] CTL_STOP  = 8'h10;
    localparam logic [7:0] CTL_START = 8'h20;
    localparam logic [7:0] CTL_EN    = 8'h40;

    localparam logic [7:0] ERR_STATUS  = 8'd1;
    localparam logic [7:0] ERR_TIMEOUT = 8'd2;

endpackage

// File: rtl/i2cseq_step_plan.sv
module i2cseq_step_plan
    import i2cseq_pkg::*;
(
    input  kind_e kind,
    input  logic  with_offset,
    input  logic  off_left,
    input  logic  data_left,
    input  step_e cur,
    output step_e nxt
);

    always_comb begin
        nxt = STEP_END;
        unique case (cur)
            STEP_START: begin
                if (kind == KIND_WRITE || (kind == KIND_READ && with_offset))
                    nxt = STEP_ADDR_W;
                else
                    nxt = STEP_ADDR_R;
            end
            STEP_ADDR_W, STEP_OFFSET: begin
                if (off_left)
                    nxt = STEP_OFFSET;
                else if (kind == KIND_WRITE)
                    nxt = data_left ? STEP_WDATA : STEP_END;
                else
                    nxt = STEP_RESTART;
            end
            STEP_WDATA:   nxt = data_left ? STEP_WDATA : STEP_END;
            STEP_RESTART: nxt = STEP_ADDR_R;
            STEP_ADDR_R,
            STEP_RDATA:   nxt = data_left ? STEP_RDATA : STEP_END;
            STEP_END:     nxt = STEP_END;
            default:      nxt = STEP_END;
        endcase
    end

endmodule

// File: rtl/i2cseq_step_decode.sv
module i2cseq_step_decode
    import i2cseq_pkg::*;
(
    input  step_e      step,
    input  logic       last_byte,
    output eng_op_e    op,
    output logic [7:0] ctrl,
    output logic [7:0] exp_code
);

    always_comb begin
        op       = OP_SEND;
        ctrl     = CTL_EN;
        exp_code = CODE_WDATA_ACK;
        unique case (step)
            STEP_START: begin
                op       = OP_START;
                ctrl     = CTL_EN | CTL_START;
                exp_code = CODE_START;
            end
            STEP_RESTART: begin
                op       = OP_START;
                ctrl     = CTL_EN | CTL_START;
                exp_code = CODE_RESTART;
            end
            STEP_ADDR_W: exp_code = CODE_ADDR_W_ACK;
            STEP_ADDR_R: exp_code = CODE_ADDR_R_ACK;
            STEP_OFFSET,
            STEP_WDATA:  exp_code = CODE_WDATA_ACK;
            STEP_RDATA: begin
                if (last_byte) begin
                    op       = OP_RECV_NAK;
                    exp_code = CODE_RDATA_NAK;
                end else begin
                    op       = OP_RECV_ACK;
                    ctrl     = CTL_EN | CTL_ACK;
                    exp_code = CODE_RDATA_ACK;
                end
            end
            STEP_END: begin
                op       = OP_STOP;
                ctrl     = CTL_EN | CTL_STOP;
                exp_code = CODE_IDLE;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/i2cseq_step_timer.sv
module i2cseq_step_timer #(
    parameter int TICK_CYCLES   = 8,
    parameter int TIMEOUT_TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);

    localparam int PRE_W = $clog2(TICK_CYCLES + 1);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (clear) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (tick_q != CNT_LAST) begin
            if (pre_q == PRE_LAST) begin
                pre_q  <= '0;
                tick_q <= tick_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (tick_q == CNT_LAST);

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2cseq_pkg::*;
#(
    parameter int OFF_BYTES     = 4,
    parameter int LEN_W         = 8,
    parameter int TICK_CYCLES   = 8,
    parameter int TIMEOUT_TICKS = 1000,
    localparam int OFF_W        = 8 * OFF_BYTES,
    localparam int OFF_CNT_W    = $clog2(OFF_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_kind,
    input  logic [6:0]           cmd_chip,
    input  logic [OFF_W-1:0]     cmd_offset,
    input  logic [OFF_CNT_W-1:0] cmd_off_cnt,
    input  logic [LEN_W-1:0]     cmd_len,
    output logic                 busy,
    output logic                 done,
    output logic [31:0]          err_word,
    input  logic [7:0]           wr_data,
    output logic                 wr_pop,
    output logic [7:0]           rd_data,
    output logic                 rd_valid,
    output logic                 eng_op_valid,
    output logic [2:0]           eng_op,
    output logic [7:0]           eng_tx,
    input  logic                 eng_flag,
    input  logic [7:0]           eng_status,
    input  logic [7:0]           eng_rx
);

    localparam logic [OFF_CNT_W-1:0] OFF_MAX = OFF_CNT_W'(OFF_BYTES);

    seq_state_e           state_q, state_d;
    step_e                step_q, plan_next;
    kind_e                kind_q;
    logic [6:0]           chip_q;
    logic [OFF_W-1:0]     offset_q;
    logic                 with_off_q;
    logic [OFF_CNT_W-1:0] off_rem_q;
    logic [LEN_W-1:0]     data_rem_q;
    logic [7:0]           ctrl_q, exp_q;
    logic [31:0]          err_q;
    logic                 err_set_q;

    eng_op_e              dec_op;
    logic [7:0]           dec_ctrl, dec_exp;
    logic                 tmr_clear, tmr_expired;
    logic [7:0]           off_byte;
    logic                 status_ok;

    i2cseq_step_plan u_plan (
        .kind        (kind_q),
        .with_offset (with_off_q),
        .off_left    (off_rem_q != '0),
        .data_left   (data_rem_q != '0),
        .cur         (step_q),
        .nxt         (plan_next)
    );

    i2cseq_step_decode u_decode (
        .step      (step_q),
        .last_byte (data_rem_q == LEN_W'(1)),
        .op        (dec_op),
        .ctrl      (dec_ctrl),
        .exp_code  (dec_exp)
    );

    i2cseq_step_timer #(
        .TICK_CYCLES   (TICK_CYCLES),
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .expired (tmr_expired)
    );

    assign tmr_clear = (state_q == ST_ISSUE) || (state_q == ST_STOP_ISSUE);
    assign status_ok = (eng_status == exp_q);

    always_comb begin
        off_byte = '0;
        for (int i = 0; i < OFF_BYTES; i++) begin
            if (off_rem_q == OFF_CNT_W'(i + 1))
                off_byte = offset_q[i*8 +: 8];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (cmd_valid) state_d = ST_ISSUE;
            ST_ISSUE:      state_d = ST_WAIT;
            ST_WAIT: begin
                if (eng_flag)
                    state_d = ST_SAMPLE;
                else if (tmr_expired)
                    state_d = ST_STOP_ISSUE;
            end
            ST_SAMPLE: begin
                if (!status_ok || plan_next == STEP_END)
                    state_d = ST_STOP_ISSUE;
                else
                    state_d = ST_ISSUE;
            end
            ST_STOP_ISSUE: state_d = ST_STOP_WAIT;
            ST_STOP_WAIT: begin
                if (eng_status == CODE_IDLE || tmr_expired)
                    state_d = ST_FINISH;
            end
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // transfer context and error capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q     <= STEP_START;
            kind_q     <= KIND_WRITE;
            chip_q     <= '0;
            offset_q   <= '0;
            with_off_q <= 1'b0;
            off_rem_q  <= '0;
            data_rem_q <= '0;
            ctrl_q     <= '0;
            exp_q      <= '0;
            err_q      <= '0;
            err_set_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        step_q     <= STEP_START;
                        kind_q     <= (cmd_kind[1]) ? KIND_PROBE : kind_e'(cmd_kind);
                        chip_q     <= cmd_chip;
                        offset_q   <= cmd_offset;
                        off_rem_q  <= (cmd_off_cnt > OFF_MAX) ? OFF_MAX : cmd_off_cnt;
                        with_off_q <= (cmd_off_cnt != '0);
                        data_rem_q <= cmd_kind[1] ? LEN_W'(1) : cmd_len;
                        err_q      <= '0;
                        err_set_q  <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    ctrl_q <= dec_ctrl;
                    exp_q  <= dec_exp;
                    if (step_q == STEP_OFFSET)
                        off_rem_q <= off_rem_q - 1'b1;
                    if (step_q == STEP_WDATA || step_q == STEP_RDATA)
                        data_rem_q <= data_rem_q - 1'b1;
                end
                ST_WAIT: begin
                    if (!eng_flag && tmr_expired) begin
                        err_q     <= {ERR_TIMEOUT, ctrl_q, eng_status, exp_q};
                        err_set_q <= 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    if (!status_ok) begin
                        err_q     <= {ERR_STATUS, ctrl_q | CTL_FLAG, eng_status, exp_q};
                        err_set_q <= 1'b1;
                    end else begin
                        step_q <= plan_next;
                    end
                end
                ST_STOP_WAIT: begin
                    if (eng_status != CODE_IDLE && tmr_expired && !err_set_q) begin
                        err_q     <= {ERR_TIMEOUT, CTL_EN | CTL_STOP, eng_status, CODE_IDLE};
                        err_set_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy         = 1'b0;
        done         = 1'b0;
        eng_op_valid = 1'b0;
        eng_op       = OP_NONE;
        eng_tx       = '0;
        wr_pop       = 1'b0;
        rd_valid     = 1'b0;
        rd_data      = eng_rx;
        err_word     = err_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                busy         = 1'b1;
                eng_op_valid = 1'b1;
                eng_op       = dec_op;
                unique case (step_q)
                    STEP_ADDR_W: eng_tx = {chip_q, 1'b0};
                    STEP_ADDR_R: eng_tx = {chip_q, 1'b1};
                    STEP_OFFSET: eng_tx = off_byte;
                    STEP_WDATA: begin
                        eng_tx = wr_data;
                        wr_pop = 1'b1;
                    end
                    default:     eng_tx = '0;
                endcase
            end
            ST_WAIT:   busy = 1'b1;
            ST_SAMPLE: begin
                busy     = 1'b1;
                rd_valid = status_ok && (step_q == STEP_RDATA);
            end
            ST_STOP_ISSUE: begin
                busy         = 1'b1;
                eng_op_valid = 1'b1;
                eng_op       = OP_STOP;
            end
            ST_STOP_WAIT: busy = 1'b1;
            ST_FINISH:    done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_xfer_seq_checker.sv
module i2c_xfer_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        busy,
    input logic        done,
    input logic [31:0] err_word,
    input logic        wr_pop,
    input logic        rd_valid,
    input logic        eng_op_valid,
    input logic [2:0]  eng_op
);

    p_op_inside_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_op_valid |-> busy);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !done) |=> busy);

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_ok_word_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_word[31:24] == 8'd0) |-> (err_word == 32'd0));

    p_class_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_word[31:24] <= 8'd2));

    p_pop_with_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |-> (eng_op_valid && eng_op == 3'd2));

    p_op_spacing_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_op_valid |=> !eng_op_valid);

    p_op_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        eng_op_valid |-> (eng_op >= 3'd1 && eng_op <= 3'd5));

    p_rd_in_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (busy && !eng_op_valid));

endmodule

bind i2c_xfer_seq i2c_xfer_seq_checker u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .done         (done),
    .err_word     (err_word),
    .wr_pop       (wr_pop),
    .rd_valid     (rd_valid),
    .eng_op_valid (eng_op_valid),
    .eng_op       (eng_op)
);

// File: tb/i2c_xfer_seq_bench.sv
`timescale 1ns/1ps
module i2c_xfer_seq_bench;

    localparam int TICK = 2;
    localparam int TMO  = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = '0;
    logic [6:0]  cmd_chip = '0;
    logic [31:0] cmd_offset = '0;
    logic [2:0]  cmd_off_cnt = '0;
    logic [7:0]  cmd_len = '0;
    logic        busy, done, wr_pop, rd_valid, eng_op_valid;
    logic [31:0] err_word;
    logic [7:0]  wr_data, rd_data, eng_tx;
    logic [2:0]  eng_op;

    // engine model state
    logic        m_flag = 1'b0, m_stage = 1'b0, m_pend = 1'b0;
    logic        m_active = 1'b0, m_addr_next = 1'b0;
    logic [7:0]  m_status = 8'hF8, m_rx = '0, m_code_pend = '0, m_rx_pend = '0;
    logic [2:0]  m_op = '0;
    logic [7:0]  m_tx = '0;
    int          m_cnt = 0, m_step = 0, m_recv_n = 0;
    int          cfg_bad = -1, cfg_hang = -1, cfg_delay = 3;
    logic        cfg_stop_hang = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0, wptr = 0;

    always #2.5 clk = ~clk;

    assign wr_data = 8'(8'hC0 + wptr);

    i2c_xfer_seq #(.TICK_CYCLES(TICK), .TIMEOUT_TICKS(TMO)) u_i2c_xfer_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_chip(cmd_chip), .cmd_offset(cmd_offset), .cmd_off_cnt(cmd_off_cnt),
        .cmd_len(cmd_len), .busy(busy), .done(done), .err_word(err_word),
        .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid),
        .eng_op_valid(eng_op_valid), .eng_op(eng_op), .eng_tx(eng_tx),
        .eng_flag(m_flag), .eng_status(m_status), .eng_rx(m_rx)
    );

    // behavioural engine: flag first, status one cycle later
    always @(posedge clk) begin
        logic [7:0] code;
        code = 8'h00;
        if (m_stage) begin
            m_status <= m_code_pend;
            m_rx     <= m_rx_pend;
            m_stage  <= 1'b0;
        end
        if (eng_op_valid) begin
            m_flag <= 1'b0;
            m_pend <= 1'b1;
            m_cnt  <= cfg_delay;
            m_op   <= eng_op;
            m_tx   <= eng_tx;
        end else if (m_pend) begin
            if (m_cnt != 0) m_cnt <= m_cnt - 1;
            else begin
                m_pend <= 1'b0;
                if (m_op == 3'd5) begin
                    m_active <= 1'b0;
                    m_step   <= 0;
                    m_recv_n <= 0;
                    if (!cfg_stop_hang) m_status <= 8'hF8;
                end else begin
                    case (m_op)
                        3'd1: begin code = m_active ? 8'h10 : 8'h08; m_active <= 1'b1; m_addr_next <= 1'b1; end
                        3'd2: begin
                            if (m_addr_next) begin code = m_tx[0] ? 8'h40 : 8'h18; m_addr_next <= 1'b0; end
                            else code = 8'h28;
                        end
                        3'd3: code = 8'h50;
                        default: code = 8'h58;
                    endcase
                    if (m_op == 3'd3 || m_op == 3'd4) begin
                        m_rx_pend <= 8'(8'h30 + m_recv_n);
                        m_recv_n  <= m_recv_n + 1;
                    end
                    if (m_step == cfg_bad) code = 8'h20;
                    if (m_step != cfg_hang) begin
                        m_flag      <= 1'b1;
                        m_stage     <= 1'b1;
                        m_code_pend <= code;
                    end
                    m_step <= m_step + 1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    int eop[$], etx[$], ectl[$], ecode[$];

    task automatic push(input int op, input int tx, input int ctl, input int code);
        eop.push_back(op); etx.push_back(tx); ectl.push_back(ctl); ecode.push_back(code);
    endtask

    task automatic run_txn(input int kind, input int chip, input logic [31:0] offs,
                           input int ocnt, input int len, input int bad, input int hang,
                           input logic shang, input int delay, input string req);
        logic [31:0] exp_err;
        int n, cut, nrd, rd_seen, base, prev, to;
        logic pop_pend;
        eop.delete(); etx.delete(); ectl.delete(); ecode.delete();
        push(1, 0, 'h60, 'h08);
        if (kind == 0 || (kind == 1 && ocnt > 0)) begin
            push(2, chip << 1, 'h40, 'h18);
            for (int i = ocnt - 1; i >= 0; i--) push(2, int'(offs[i*8 +: 8]), 'h40, 'h28);
            if (kind == 0) begin
                for (int j = 0; j < len; j++) push(2, 256 + j, 'h40, 'h28);
            end else begin
                push(1, 0, 'h60, 'h10);
                push(2, (chip << 1) | 1, 'h40, 'h40);
            end
        end else begin
            push(2, (chip << 1) | 1, 'h40, 'h40);
        end
        if (kind != 0) begin
            int cnt;
            cnt = (kind == 2) ? 1 : len;
            for (int j = 0; j < cnt; j++) begin
                if (j == cnt - 1) push(4, 0, 'h40, 'h58);
                else              push(3, 0, 'h44, 'h50);
            end
        end
        n = eop.size();
        cut = n;
        exp_err = 32'd0;
        if (bad >= 0 && bad < n) begin
            exp_err = {8'd1, 8'(ectl[bad] | 'h08), 8'h20, 8'(ecode[bad])};
            cut = bad + 1;
        end else if (hang >= 0 && hang < n) begin
            prev = (hang == 0) ? 'hF8 : ecode[hang-1];
            exp_err = {8'd2, 8'(ectl[hang]), 8'(prev), 8'(ecode[hang])};
            cut = hang + 1;
        end else if (shang) begin
            exp_err = {8'd2, 8'h50, 8'(ecode[n-1]), 8'hF8};
        end
        nrd = 0;
        for (int i = 0; i < n; i++) begin
            if ((eop[i] == 3 || eop[i] == 4) && (i < cut - 1 || cut == n)) nrd++;
        end
        while (eop.size() > cut) begin
            void'(eop.pop_back()); void'(etx.pop_back()); void'(ectl.pop_back()); void'(ecode.pop_back());
        end
        push(5, 0, 'h50, 'hF8);

        cfg_bad = bad; cfg_hang = hang; cfg_stop_hang = shang; cfg_delay = delay;
        base = wptr;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'(kind); cmd_chip = 7'(chip);
        cmd_offset = offs; cmd_off_cnt = 3'(ocnt); cmd_len = 8'(len);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        rd_seen = 0; pop_pend = 1'b0; to = 0;
        while (!done && to < 20000) begin
            if (pop_pend) begin wptr++; pop_pend = 1'b0; end
            if (eng_op_valid) begin
                if (eop.size() == 0) begin
                    chk(1'b0, {req, " unexpected step"}, eng_op, 0);
                end else begin
                    int xo, xt;
                    xo = eop.pop_front(); xt = etx.pop_front();
                    void'(ectl.pop_front()); void'(ecode.pop_front());
                    chk(eng_op == 3'(xo), {req, " R12 step opcode"}, eng_op, xo);
                    if (xo == 2) begin
                        if (xt >= 256) xt = (8'hC0 + base + xt - 256) & 8'hFF;
                        chk(eng_tx == 8'(xt), {req, " R3 sent byte"}, eng_tx, xt);
                    end
                end
                if (wr_pop) pop_pend = 1'b1;
            end
            if (rd_valid) begin
                chk(rd_data == 8'(8'h30 + rd_seen), {req, " R6 read byte"}, rd_data, 8'h30 + rd_seen);
                rd_seen++;
            end
            @(negedge clk);
            to++;
        end
        if (pop_pend) wptr++;
        chk(done == 1'b1, {req, " R2 done reached"}, done, 1);
        chk(busy == 1'b0, {req, " R2 idle at done"}, busy, 0);
        chk(err_word == exp_err, {req, " R9 R10 R11 error word"}, err_word, exp_err);
        chk(eop.size() == 0, {req, " R11 remaining steps incl stop"}, eop.size(), 0);
        chk(rd_seen == nrd, {req, " R6 read count"}, rd_seen, nrd);
        @(negedge clk);
        chk(done == 1'b0, {req, " R2 done one cycle"}, done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && eng_op_valid == 0 && rd_valid == 0 && wr_pop == 0,
            "R1 reset outputs", {busy, done, eng_op_valid}, 0);
        chk(err_word == 0, "R1 reset error word", err_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && eng_op_valid == 0, "R1 idle after reset", busy, 0);

        run_txn(0, 'h50, 32'h0000_1234, 2, 3, -1, -1, 1'b0, 3, "R3 write two offsets");
        run_txn(0, 'h21, 32'hAABB_CCDD, 4, 0, -1, -1, 1'b0, 2, "R3 write four offsets");
        run_txn(1, 'h1A, 32'h0000_0007, 1, 3, -1, -1, 1'b0, 3, "R4 combined read");
        run_txn(1, 'h2B, 32'h0000_0000, 0, 1, -1, -1, 1'b0, 1, "R5 direct read");
        run_txn(1, 'h11, 32'h0000_0000, 0, 4, -1, -1, 1'b0, 0, "R6 R8 read fast engine");
        run_txn(2, 'h3C, 32'h0000_0000, 0, 0, -1, -1, 1'b0, 3, "R7 probe");
        run_txn(1, 'h12, 32'h0000_0000, 0, 0, -1, -1, 1'b0, 2, "R6 zero length read");
        run_txn(0, 'h44, 32'h0000_0056, 1, 2, 1, -1, 1'b0, 3, "R9 address nak");
        run_txn(1, 'h45, 32'h0000_0102, 2, 3, -1, 5, 1'b0, 3, "R10 step timeout");
        run_txn(0, 'h46, 32'h0000_0000, 0, 1, -1, -1, 1'b1, 3, "R11 stop timeout");
        run_txn(0, 'h47, 32'h0000_0009, 1, 2, 2, -1, 1'b1, 3, "R11 first error kept");
        run_txn(1, 'h48, 32'h0000_00AB, 1, 1, -1, -1, 1'b0, 1500, "R10 slow but in window");

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule